// File: doc/BRIEF.md
# Two-Wire Serial Command Receiver

This block is the slave side of a small two-wire link from an external microcontroller. One line carries the data and also marks the frame. The other line carries the serial clock. Both lines idle high. When the data line drops while the receiver is idle, a frame opens. The receiver treats that as a request to halt what the chip is doing, and signals this by pulling `busy_o` low.

The data line has to stay low for a full debounce window. Once it has, the shift buffer is cleared and the receiver accepts data bits, least significant first, on rising edges of the serial clock. The data line may change only while the clock is low. A rise of the data line while the clock is high closes the frame. If eight bits have been taken by then, the byte appears on `vec_o` as a command vector, together with a one-cycle strobe, and `busy_o` goes high again. When the last bit is a 1 the line is already high, so the frame closes right after the final clock edge and there is no wait for a release.

Both lines are brought into the system clock domain through a synchronizer chain. The system clock must therefore be fast enough to see every level of the serial clock for several cycles.

Top module: `ser_cmd_rx`

## Requirements
- R1: After reset, `busy_o` is 1, `vec_stb_o` is 0 and `vec_o` is all zeros.
- R2: When `data_i` falls while the receiver is idle, `busy_o` is still 1 after the second rising clock edge and is 0 after the third.
- R3: `data_i` must stay low for DEB_CYCLES system cycles before bits are accepted. If it returns high earlier, the frame is abandoned: `busy_o` goes back to 1 and no strobe is issued.
- R4: Serial clock rises that occur before the debounce window completes are discarded. The shift buffer is cleared when the window completes.
- R5: Data bits are sampled on rising edges of the synchronized serial clock, least significant bit first. Bit i of the transfer lands in bit i of `vec_o`.
- R6: When the eighth bit is 0, the frame closes when `data_i` rises while `sclk_i` is high. `vec_stb_o` and `busy_o` are 1 after the third rising clock edge following that rise, and `vec_o` then holds the byte.
- R7: When the eighth bit is 1, the frame closes without any release. `vec_stb_o` is 0 after the third rising clock edge following the eighth `sclk_i` rise, and 1 (with `busy_o` 1 and `vec_o` set) after the fourth.
- R8: A frame that closes after fewer than eight bits is dropped. No strobe is issued, `vec_o` keeps its previous byte, and `busy_o` returns to 1 at the time R6 gives.
- R9: Serial clock rises after the eighth bit are ignored and do not shift the byte.
- R10: `vec_stb_o` is high for exactly one cycle per accepted frame, and `vec_o` changes only in a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_i | input | 1 | Serial data and frame line, idles high |
| sclk_i | input | 1 | Serial clock, idles high, 10 kHz to 1 MHz |
| vec_o | output | DATA_W | Last accepted command vector |
| vec_stb_o | output | 1 | One-cycle pulse when a new vector is delivered |
| busy_o | output | 1 | Low while a frame is in progress, high otherwise |

## Verification
Every result is due a fixed number of system clock edges after the stimulus that causes it. The halt indication comes three edges after the data line falls. The strobe for a frame closed by a release comes three edges after the release. The strobe for a frame ending in a 1 bit comes four edges after the last serial clock rise. The bench drives inputs just after a rising edge, counts exactly that many edges, and samples on the following falling edge. It also samples one edge earlier to confirm the result has not yet appeared, and one edge later to confirm the strobe has already dropped. A strobe counter on the falling edge shows that dropped and abandoned frames produce no pulse at all.

// File: rtl/ser_cmd_rx_pkg.sv
package ser_cmd_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEB   = 2'd1,
    ST_SHIFT = 2'd2
  } rx_state_e;

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/scr_deb_timer.sv
module scr_deb_timer #(
  parameter int CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == CW'(CYCLES - 1));

  always_comb begin
    if (!run) begin
      cnt_d = '0;
    end else if (done) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/scr_shift.sv
module scr_shift #(
  parameter  int W  = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          din,
  output logic [W-1:0]  word,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [W-1:0]  word_q, word_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == CW'(W));
  assign word  = word_q;
  assign count = cnt_q;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clr) begin
      word_d = '0;
      cnt_d  = '0;
    end else if (shift_en && !full) begin
      word_d = {din, word_q[W-1:1]};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/ser_cmd_rx.sv
module ser_cmd_rx
  import ser_cmd_rx_pkg::*;
#(
  parameter  int DATA_W      = 8,
  parameter  int DEB_CYCLES  = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int CW          = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_i,
  input  logic              sclk_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_stb_o,
  output logic              busy_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  // line synchronizers, both lines idle high
  logic [1:0] line_s;
  logic       data_s, sclk_s;

  scr_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b11)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({data_i, sclk_i}),
    .q     (line_s)
  );

  assign data_s = line_s[1];
  assign sclk_s = line_s[0];

  // edge history
  logic data_q, sclk_q;
  logic data_rise, sclk_rise;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      data_q <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      data_q <= data_s;
      sclk_q <= sclk_s;
    end
  end

  assign data_rise = data_s && !data_q;
  assign sclk_rise = sclk_s && !sclk_q;

  // state
  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] vec_q, vec_d;
  logic              stb_q, stb_d;

  // debounce window
  logic deb_run, deb_done;

  assign deb_run = (state_q == ST_DEB) && !data_s;

  scr_deb_timer #(
    .CYCLES (DEB_CYCLES)
  ) u_deb (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (deb_run),
    .done  (deb_done)
  );

  // shift buffer
  logic [DATA_W-1:0] shift_word;
  logic [CW-1:0]     bit_cnt;
  logic              shift_full;
  logic              shift_en;

  assign shift_en = (state_q == ST_SHIFT) && sclk_rise;

  scr_shift #(
    .W (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr      (deb_done),
    .shift_en (shift_en),
    .din      (data_s),
    .word     (shift_word),
    .count    (bit_cnt),
    .full     (shift_full)
  );

  // frame sequencing
  always_comb begin
    state_d = state_q;
    vec_d   = vec_q;
    stb_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!data_s) state_d = ST_DEB;
      end
      ST_DEB: begin
        if (data_s) begin
          state_d = ST_IDLE;
        end else if (deb_done) begin
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (shift_full && data_s) begin
          state_d = ST_IDLE;
          vec_d   = shift_word;
          stb_d   = 1'b1;
        end else if (data_rise && sclk_s) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vec_q   <= vec_d;
      stb_q   <= stb_d;
    end
  end

  assign vec_o     = vec_q;
  assign vec_stb_o = stb_q;
  assign busy_o    = (state_q == ST_IDLE);

endmodule

// File: rtl/ser_cmd_rx_chk.sv
module ser_cmd_rx_chk #(
  parameter  int DATA_W = 8,
  localparam int CW     = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] vec_o,
  input logic              vec_stb_o,
  input logic              busy_o,
  input logic [CW-1:0]     bit_cnt,
  input logic              shift_full
);

  // R10: the strobe never lasts two cycles
  a_r10_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb_o |=> !vec_stb_o);

  // R10: the vector only moves together with its strobe
  a_r10_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vec_o) |-> vec_stb_o);

  // R6: a delivered vector comes with the receiver free again
  a_r6_stb_busy: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb_o |-> busy_o);

  // R8: a strobe requires a completely filled buffer
  a_r8_stb_full: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb_o |-> $past(shift_full));

  // R9: the bit count never passes the byte width
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(DATA_W));

endmodule

bind ser_cmd_rx ser_cmd_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vec_o      (vec_o),
  .vec_stb_o  (vec_stb_o),
  .busy_o     (busy_o),
  .bit_cnt    (bit_cnt),
  .shift_full (shift_full)
);

// File: tb/tb_ser_cmd_rx.sv
`timescale 1ns/1ps
module tb_ser_cmd_rx;

  localparam int DEB = 32;
  localparam int HB  = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       data_i;
  logic       sclk_i;
  logic [7:0] vec_o;
  logic       vec_stb_o;
  logic       busy_o;

  int checks   = 0;
  int errors   = 0;
  int stb_seen = 0;
  bit done     = 1'b0;
  logic [7:0] last_vec = 8'h00;

  always #5 clk = ~clk;

  ser_cmd_rx #(.DATA_W(8), .DEB_CYCLES(DEB), .SYNC_STAGES(2)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_i    (data_i),
    .sclk_i    (sclk_i),
    .vec_o     (vec_o),
    .vec_stb_o (vec_stb_o),
    .busy_o    (busy_o)
  );

  always @(negedge clk) if (vec_stb_o) stb_seen++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; data_i = 1'b1; sclk_i = 1'b1;
    step(5);
    rst_n = 1'b1;
    step(4);
    @(negedge clk);
    check(busy_o == 1'b1, "R1", "busy after reset", busy_o, 1);
    check(vec_stb_o == 1'b0, "R1", "strobe after reset", vec_stb_o, 0);
    check(vec_o == 8'h00, "R1", "vector after reset", vec_o, 0);
    step(1);
  endtask

  // one frame: nbits bits of b, pre clocks inside debounce, extra clocks after bit 8
  task automatic run_frame(input logic [7:0] b, input int nbits,
                           input int pre, input int extra, input string req);
    int s0;
    s0 = stb_seen;
    data_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(busy_o == 1'b1, "R2", "busy two edges after fall", busy_o, 1);
    @(posedge clk);
    @(negedge clk);
    check(busy_o == 1'b0, "R2", "busy three edges after fall", busy_o, 0);
    step(1);
    for (int k = 0; k < pre; k++) begin
      sclk_i = 1'b0; step(HB);
      sclk_i = 1'b1; step(HB);
    end
    step(DEB + 4);
    for (int i = 0; i < nbits; i++) begin
      sclk_i = 1'b0; step(HB);
      data_i = b[i]; step(HB);
      sclk_i = 1'b1;
      if (i != nbits - 1) step(HB);
    end
    if (nbits == 8 && b[7] && extra == 0) begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(vec_stb_o == 1'b0, "R7", "strobe three edges after last clock", vec_stb_o, 0);
      @(posedge clk);
      @(negedge clk);
      check(vec_stb_o == 1'b1, "R7", "strobe four edges after last clock", vec_stb_o, 1);
      check(busy_o == 1'b1, "R7", "busy with strobe", busy_o, 1);
      check(vec_o == b, {req, " R5"}, "vector", vec_o, b);
      @(posedge clk);
      @(negedge clk);
      check(vec_stb_o == 1'b0, "R10", "strobe one cycle", vec_stb_o, 0);
      last_vec = b;
      step(1);
    end else begin
      step(HB);
      for (int k = 0; k < extra; k++) begin
        sclk_i = 1'b0; step(HB);
        data_i = 1'b0; step(HB);
        sclk_i = 1'b1; step(HB);
      end
      data_i = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(vec_stb_o == 1'b0, req, "strobe two edges after release", vec_stb_o, 0);
      check(busy_o == 1'b0, req, "busy two edges after release", busy_o, 0);
      @(posedge clk);
      @(negedge clk);
      check(busy_o == 1'b1, req, "busy three edges after release", busy_o, 1);
      if (nbits == 8) begin
        check(vec_stb_o == 1'b1, "R6", "strobe three edges after release", vec_stb_o, 1);
        check(vec_o == b, {req, " R5"}, "vector", vec_o, b);
        @(posedge clk);
        @(negedge clk);
        check(vec_stb_o == 1'b0, "R10", "strobe one cycle", vec_stb_o, 0);
        last_vec = b;
      end else begin
        check(vec_stb_o == 1'b0, "R8", "no strobe for short frame", vec_stb_o, 0);
      end
      step(1);
    end
    step(6);
    @(negedge clk);
    check(stb_seen == s0 + ((nbits == 8) ? 1 : 0), req, "strobe count", stb_seen, s0 + ((nbits == 8) ? 1 : 0));
    check(vec_o == last_vec, "R10", "vector held after frame", vec_o, last_vec);
    step(2 * HB);
  endtask

  task automatic test_glitch();
    int s0;
    s0 = stb_seen;
    data_i = 1'b0;
    step(DEB / 2);
    data_i = 1'b1;
    step(6);
    @(negedge clk);
    check(busy_o == 1'b1, "R3", "busy after short low", busy_o, 1);
    check(stb_seen == s0, "R3", "no strobe after short low", stb_seen, s0);
    check(vec_o == last_vec, "R3", "vector after short low", vec_o, last_vec);
    step(2 * HB);
  endtask

  initial begin
    test_reset();
    run_frame(8'hC3, 8, 0, 0, "R7");
    run_frame(8'h22, 8, 0, 0, "R6");
    run_frame(8'h01, 8, 0, 0, "R5");
    run_frame(8'h0B, 5, 0, 0, "R8");
    test_glitch();
    run_frame(8'h5A, 8, 2, 0, "R4");
    run_frame(8'h3C, 8, 0, 2, "R9");
    run_frame(8'h81, 8, 0, 0, "R3");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule